// File: doc/BRIEF.md
# Multi-Position Rotate Through Carry

This block rotates a 32-bit data word together with a carry flag as one 33-bit ring. A single operation moves the ring left or right by any count from 0 to 63. The count is taken modulo 33, so one request does the work of a whole chain of single-bit rotate-through-carry steps. A left rotate moves bits toward the carry through the top of the word. A right rotate moves bits toward the carry through the bottom of the word.

A request is presented with `valid_i` together with the word, the carry, the direction and the count. The rotated word and the new carry appear registered on the next cycle, marked by `valid_o`. Between requests the outputs keep the last result.

Top module: `carry_ring_rotator`

## Requirements
- R1: Left rotate (`dir_left_i`=1) treats the ring as {carry, data[31:0]}. Each position moves data[31] into carry and the old carry into data[0], and a count k applies k such steps.
- R2: Right rotate (`dir_left_i`=0) treats the ring as {data[31:0], carry}. Each position moves data[0] into carry and the old carry into data[31], and a count k applies k such steps.
- R3: The 6-bit count is reduced modulo 33. Counts 0 and 33 leave data and carry unchanged, and a count c of 33 or more gives the same result as c-33.
- R4: A count of 1 gives exactly one single-bit rotate through carry in the selected direction.
- R5: `valid_o` is high in the cycle after `valid_i` was sampled high and low otherwise. `data_o`/`carry_o` carry that request's result in the same cycle.
- R6: While `valid_i` is low, `data_o` and `carry_o` hold their last values whatever the other inputs do.
- R7: After the asynchronous active-low reset, `valid_o`, `data_o` and `carry_o` are all 0.
- R8: The number of ones in {carry_o, data_o} equals the number of ones in the requested {carry_i, data_i}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| data_i | input | 32 | Data word to rotate |
| carry_i | input | 1 | Carry flag entering the ring |
| dir_left_i | input | 1 | 1 = rotate left, 0 = rotate right |
| count_i | input | 6 | Rotate count, taken modulo 33 |
| valid_o | output | 1 | Result valid, one cycle after the request |
| data_o | output | 32 | Rotated data word |
| carry_o | output | 1 | Carry flag leaving the ring |

## Verification
The hardest cases to reach are those where the modulo reduction and the direction mapping meet. Examples are a right rotate by 32 or 34, which must act like a left or right single step, and counts of 33 and above, which wrap. Random data and carry with uniformly drawn 6-bit counts rarely land exactly on these values. So the table holds directed vectors with a single set bit for counts 0, 1, 32, 33, 34 and 63 in both directions. A random sweep over all counts then follows, checked against a step-by-step ring model.

// File: rtl/carry_ring_pkg.sv
package carry_ring_pkg;
  localparam int DATA_W = 32;
  localparam int RING_W = DATA_W + 1;
  localparam int CNT_W  = 6;
  localparam int AMT_W  = $clog2(RING_W);
endpackage

// File: rtl/ring_count_norm.sv
// Reduces the count modulo the ring width; a right rotate becomes a left
// rotate by the complement so one rotator serves both directions.
module ring_count_norm #(
  parameter int RING_W = carry_ring_pkg::RING_W,
  parameter int CNT_W  = carry_ring_pkg::CNT_W,
  parameter int AMT_W  = carry_ring_pkg::AMT_W
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic             dir_left_i,
  output logic [AMT_W-1:0] amt_o
);
  localparam int WIDE = (CNT_W > AMT_W ? CNT_W : AMT_W) + 1;

  logic [WIDE-1:0] red;

  always_comb begin
    red = WIDE'(count_i) % WIDE'(RING_W);
    if (dir_left_i || red == '0) amt_o = AMT_W'(red);
    else                         amt_o = AMT_W'(WIDE'(RING_W) - red);
  end
endmodule

// File: rtl/ring_barrel.sv
// Logarithmic left rotator over the full ring.
module ring_barrel #(
  parameter int RING_W = carry_ring_pkg::RING_W,
  parameter int AMT_W  = carry_ring_pkg::AMT_W
) (
  input  logic [RING_W-1:0] ring_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [RING_W-1:0] ring_o
);
  logic [RING_W-1:0] st [AMT_W+1];

  assign st[0] = ring_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = (1 << s) % RING_W;
    if (SH == 0) begin : g_pass
      assign st[s+1] = st[s];
    end else begin : g_rot
      assign st[s+1] = amt_i[s] ? {st[s][RING_W-1-SH:0], st[s][RING_W-1:RING_W-SH]}
                                : st[s];
    end
  end

  assign ring_o = st[AMT_W];
endmodule

// File: rtl/carry_ring_rotator.sv
module carry_ring_rotator
  import carry_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  input  logic              dir_left_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              carry_o
);
  logic [AMT_W-1:0]  amt;
  logic [RING_W-1:0] ring_rot;

  ring_count_norm #(.RING_W(RING_W), .CNT_W(CNT_W), .AMT_W(AMT_W)) u_norm (
    .count_i    (count_i),
    .dir_left_i (dir_left_i),
    .amt_o      (amt)
  );

  // ring order {carry, data}: carry sits above data[DATA_W-1]
  ring_barrel #(.RING_W(RING_W), .AMT_W(AMT_W)) u_barrel (
    .ring_i (RING_W'({carry_i, data_i})),
    .amt_i  (amt),
    .ring_o (ring_rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      carry_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= ring_rot[DATA_W-1:0];
        carry_o <= ring_rot[RING_W-1];
      end
    end
  end
endmodule

// File: rtl/carry_ring_rotator_chk.sv
module carry_ring_rotator_chk
  import carry_ring_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              carry_i,
  input logic              dir_left_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic              carry_o
);
  // R5
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R5
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(carry_o)));
  // R3
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (count_i == 6'd0 || count_i == 6'd33)) |=>
      (data_o == $past(data_i) && carry_o == $past(carry_i)));
  // R4
  left_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dir_left_i && count_i == 6'd1) |=>
      ({carry_o, data_o} == {$past(data_i), $past(carry_i)}));
  // R4
  right_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dir_left_i && count_i == 6'd1) |=>
      ({data_o, carry_o} == {$past(carry_i), $past(data_i)}));
  // R8
  ones_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($countones({carry_o, data_o}) == $countones($past({carry_i, data_i}))));
endmodule

bind carry_ring_rotator carry_ring_rotator_chk u_chk (.*);

// File: tb/carry_ring_rotator_bench.sv
`timescale 1ns/1ps
module carry_ring_rotator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        carry_i = 1'b0;
  logic        dir_left_i = 1'b0;
  logic [5:0]  count_i = '0;
  logic        valid_o;
  logic [31:0] data_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  carry_ring_rotator u_carry_ring_rotator (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .carry_i(carry_i), .dir_left_i(dir_left_i), .count_i(count_i),
    .valid_o(valid_o), .data_o(data_o), .carry_o(carry_o)
  );

  typedef struct packed {
    logic        left;
    logic [5:0]  cnt;
    logic        c;
    logic [31:0] d;
    logic        ec;
    logic [31:0] ed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd1,  1'b0, 32'h0000_0001, 1'b0, 32'h0000_0002},  // R1 R4
    '{1'b1, 6'd1,  1'b0, 32'h8000_0000, 1'b1, 32'h0000_0000},  // R1 R4
    '{1'b1, 6'd1,  1'b1, 32'h0000_0000, 1'b0, 32'h0000_0001},  // R1 R4
    '{1'b0, 6'd1,  1'b0, 32'h0000_0001, 1'b1, 32'h0000_0000},  // R2 R4
    '{1'b0, 6'd1,  1'b1, 32'h0000_0000, 1'b0, 32'h8000_0000},  // R2 R4
    '{1'b1, 6'd33, 1'b1, 32'h1234_5678, 1'b1, 32'h1234_5678},  // R3
    '{1'b0, 6'd33, 1'b0, 32'hCAFE_0001, 1'b0, 32'hCAFE_0001},  // R3
    '{1'b1, 6'd32, 1'b0, 32'h0000_0001, 1'b1, 32'h0000_0000},  // R1
    '{1'b0, 6'd32, 1'b1, 32'h0000_0000, 1'b0, 32'h0000_0001},  // R2
    '{1'b1, 6'd63, 1'b0, 32'h0000_0001, 1'b0, 32'h4000_0000},  // R3
    '{1'b0, 6'd34, 1'b0, 32'h0000_0002, 1'b0, 32'h0000_0001},  // R3
    '{1'b1, 6'd0,  1'b1, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF}   // R3
  };

  function automatic logic [32:0] ref_rot(logic [31:0] d, logic c, logic left, logic [5:0] cnt);
    logic nc;
    for (int i = 0; i < int'(cnt) % 33; i++) begin
      if (left) begin nc = d[31]; d = {d[30:0], c}; c = nc; end
      else      begin nc = d[0];  d = {c, d[31:1]}; c = nc; end
    end
    return {c, d};
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] d, logic c, logic left, logic [5:0] cnt);
    @(negedge clk);
    data_i = d; carry_i = c; dir_left_i = left; count_i = cnt; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] exp;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", {valid_o, carry_o, data_o[30:0]}, '0);
    check("R7", {1'b0, data_o}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].d, VECS[i].c, VECS[i].left, VECS[i].cnt);
      check(VECS[i].left ? "R1/R3/R4 left" : "R2/R3/R4 right",
            {carry_o, data_o}, {VECS[i].ec, VECS[i].ed});
      check("R5 valid", {32'd0, valid_o}, 33'd1);
    end

    // R5: valid drops after the request
    @(negedge clk);
    check("R5 idle", {32'd0, valid_o}, 33'd0);

    // R6: inputs change without strobe, outputs hold
    apply(32'hA5A5_0F0F, 1'b1, 1'b1, 6'd5);
    exp = {carry_o, data_o};
    data_i = 32'h1111_2222; carry_i = 1'b0; count_i = 6'd7; dir_left_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 hold", {carry_o, data_o}, exp);
    check("R6 hold", exp, ref_rot(32'hA5A5_0F0F, 1'b1, 1'b1, 6'd5));

    // R1 R2 R3: random sweep against step model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic c, l;
      logic [5:0] n;
      d = $urandom; c = 1'($urandom); l = 1'($urandom); n = 6'(i % 64);
      apply(d, c, l, n);
      check(l ? "R1 random left" : "R2 random right", {carry_o, data_o}, ref_rot(d, c, l, n));
      check("R8 ones", 33'($countones({carry_o, data_o})), 33'($countones({c, d})));
    end

    // R7: reset mid-run clears outputs
    apply(32'hFFFF_FFFF, 1'b1, 1'b1, 6'd3);
    rst_n = 1'b0;
    #1;
    check("R7 async", {carry_o, data_o}, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule